// File: doc/BRIEF.md
# Sector Protection Register SPI Engine

This block is the serial command handler for the per-sector protection store of a flash array. It sits behind an SPI slave port and owns one byte per sector. Those bytes are held as a register that the rest of the memory sees as a flat vector of "sector protected" flags.

Two commands are decoded. A program command opens with a fixed four-byte prefix. The data bytes that follow are staged and then committed to the register only after chip select is released, during a self-timed interval that is modelled by a cycle counter. A read command is a single opcode followed by three don't-care bytes; after that the register streams out one byte per sector on SO.

All SPI pins are sampled into the system clock domain. The SO output is a data bit paired with an output-enable, and a pad cell turns that pair into a three-state pin.

Top module: `sprot_spi_engine`

## Requirements
- R1: A program command is accepted only when the first four bytes after CS falls are 0x3D, 0x2A, 0x7F, 0xFC in that order. If any of these bytes differs, the rest of that selection is ignored: busy does not rise and the register is unchanged.
- R2: Data byte k of a program command is stored at sector (k mod NUM_SECT). A byte past the last sector wraps to sector 0 and overwrites what an earlier byte of the same command put there.
- R3: Sectors that receive no data byte in a program command keep their previous contents.
- R4: Staged bytes are committed only after CS rises. Busy is then high for exactly PROG_CYCLES clock cycles, and sect_prot does not change until busy falls.
- R5: A read command is 0x32 followed by three bytes of any value. After those bytes, SO carries register bytes 0, 1, 2 … in order, MSB first, in SPI mode 0: SI is sampled on the SCK rising edge and SO changes on the SCK falling edge.
- R6: spi_so_oe is high only during the data phase of a read. It is low again within a few clock cycles of CS rising.
- R7: sect_prot[k] is 1 only when prot_en is 1 and register byte k equals 0xFF. Every other byte value, 0x00 included, reads as unprotected.
- R8: A program command is accepted and committed whether prot_en is 0 or 1.
- R9: Any selection that begins (CS falls) while busy is high is ignored until CS rises again. Such a program does not start, and such a read never drives SO.
- R10: After reset every register byte is 0x00, busy is 0, sect_prot is all zero and spi_so_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_si | input | 1 | Serial data in, MSB first |
| prot_en | input | 1 | Global sector protection enable |
| spi_so | output | 1 | Serial data out bit |
| spi_so_oe | output | 1 | Output enable for the SO pad |
| busy | output | 1 | High during the self-timed program interval |
| sect_prot | output | NUM_SECT | Per-sector protected flags |

## Verification
A staging pointer that slips, or a valid mask that is stale, shows up as a wrong byte at a single sector position. On sect_prot this appears the cycle busy falls; in the serial readout it appears at that byte's slot. A decoder stuck in the wrong state shows up either as busy rising after a broken prefix or as the output enable asserting during a read issued while busy. Both are visible a few clock cycles after CS moves. An interval counter that is off by even one cycle is caught by measuring the length of the busy pulse.

// File: rtl/sprot_pkg.sv
package sprot_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_READ   = 8'h32;
    localparam logic [BYTE_W-1:0] LOCK_VALUE = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_PDATA,
        ST_RDUMMY,
        ST_RDATA,
        ST_SKIP
    } sel_st_t;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_fall;
        logic cs_rise;
        logic cs_act;
        logic si;
    } spi_ev_t;

    function automatic logic [BYTE_W-1:0] pfx_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h3D;
            2'd1:    return 8'h2A;
            2'd2:    return 8'h7F;
            default: return 8'hFC;
        endcase
    endfunction

    function automatic logic is_locked(input logic [BYTE_W-1:0] b);
        return b == LOCK_VALUE;
    endfunction

endpackage

// File: rtl/sprot_spi_sync.sv
module sprot_spi_sync
    import sprot_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sck,
    input  logic    cs_n,
    input  logic    si,
    output spi_ev_t ev
);
    localparam int unsigned NSIG = 3;
    localparam logic [NSIG-1:0] RST_VAL = 3'b010;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] cur_v;
    logic [NSIG-1:0] prev_v;

    assign raw = {sck, cs_n, si};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [SYNC_STAGES:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= {(SYNC_STAGES+1){RST_VAL[g]}};
            else     pipe <= {pipe[SYNC_STAGES-1:0], raw[g]};
        end
        assign cur_v[g]  = pipe[SYNC_STAGES-1];
        assign prev_v[g] = pipe[SYNC_STAGES];
    end

    always_comb begin
        ev.sck_rise = cur_v[2] & ~prev_v[2];
        ev.sck_fall = ~cur_v[2] & prev_v[2];
        ev.cs_fall  = ~cur_v[1] & prev_v[1];
        ev.cs_rise  = cur_v[1] & ~prev_v[1];
        ev.cs_act   = ~cur_v[1];
        ev.si       = cur_v[0];
    end
endmodule

// File: rtl/sprot_cmd_fsm.sv
module sprot_cmd_fsm
    import sprot_pkg::*;
#(
    parameter int unsigned PTR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  spi_ev_t           ev,
    input  logic              busy,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              stg_clr,
    output logic              stg_wr,
    output logic [BYTE_W-1:0] stg_data,
    output logic              prog_go,
    output logic [PTR_W-1:0]  rd_idx,
    output logic              so_bit,
    output logic              so_oe
);
    localparam int unsigned BIT_W = $clog2(BYTE_W);

    sel_st_t           st, st_n;
    logic [BYTE_W-2:0] shreg;
    logic [BIT_W-1:0]  bcnt;
    logic [1:0]        pcnt, pcnt_n;
    logic [BIT_W-1:0]  obit;
    logic              byte_done;
    logic [BYTE_W-1:0] new_byte;

    assign byte_done = ev.sck_rise && ev.cs_act && (bcnt == BIT_W'(BYTE_W-1));
    assign new_byte  = {shreg, ev.si};
    assign stg_data  = new_byte;
    assign so_oe     = (st == ST_RDATA);

    always_comb begin
        st_n    = st;
        pcnt_n  = pcnt;
        stg_clr = 1'b0;
        stg_wr  = 1'b0;
        prog_go = 1'b0;
        if (ev.cs_rise) begin
            prog_go = (st == ST_PDATA);
            st_n    = ST_IDLE;
        end else if (ev.cs_fall) begin
            st_n   = busy ? ST_SKIP : ST_OPC;
            pcnt_n = 2'd0;
        end else if (byte_done) begin
            case (st)
                ST_OPC: begin
                    if (pcnt == 2'd0 && new_byte == OPC_READ) begin
                        st_n   = ST_RDUMMY;
                        pcnt_n = 2'd0;
                    end else if (new_byte == pfx_byte(pcnt)) begin
                        if (pcnt == 2'd3) begin
                            st_n    = ST_PDATA;
                            stg_clr = 1'b1;
                        end
                        pcnt_n = pcnt + 2'd1;
                    end else begin
                        st_n = ST_SKIP;
                    end
                end
                ST_PDATA: stg_wr = 1'b1;
                ST_RDUMMY: begin
                    if (pcnt == 2'd2) st_n = ST_RDATA;
                    pcnt_n = pcnt + 2'd1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            pcnt   <= '0;
            shreg  <= '0;
            bcnt   <= '0;
            obit   <= '0;
            rd_idx <= '0;
            so_bit <= 1'b0;
        end else begin
            st   <= st_n;
            pcnt <= pcnt_n;
            if (ev.cs_fall) begin
                bcnt <= '0;
            end else if (ev.sck_rise && ev.cs_act) begin
                shreg <= {shreg[BYTE_W-3:0], ev.si};
                bcnt  <= bcnt + 1'b1;
            end
            if (st != ST_RDATA) begin
                rd_idx <= '0;
                obit   <= '0;
            end else if (ev.sck_fall) begin
                so_bit <= rd_byte[BIT_W'(BYTE_W-1) - obit];
                obit   <= obit + 1'b1;
                if (obit == BIT_W'(BYTE_W-1)) rd_idx <= rd_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sprot_store.sv
module sprot_store
    import sprot_pkg::*;
#(
    parameter int unsigned NUM_SECT    = 64,
    parameter int unsigned PTR_W       = 6,
    parameter int unsigned PROG_CYCLES = 2000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stg_clr,
    input  logic                stg_wr,
    input  logic [BYTE_W-1:0]   stg_data,
    input  logic                prog_go,
    input  logic [PTR_W-1:0]    rd_idx,
    input  logic                prot_en,
    output logic [BYTE_W-1:0]   rd_byte,
    output logic                busy,
    output logic [NUM_SECT-1:0] sect_prot
);
    localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1);

    logic [BYTE_W-1:0]   cur [NUM_SECT];
    logic [BYTE_W-1:0]   stg [NUM_SECT];
    logic [NUM_SECT-1:0] stg_vld;
    logic [PTR_W-1:0]    wptr;
    logic [CNT_W-1:0]    tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_vld <= '0;
            wptr    <= '0;
            for (int i = 0; i < NUM_SECT; i++) stg[i] <= '0;
        end else if (stg_clr) begin
            stg_vld <= '0;
            wptr    <= '0;
        end else if (stg_wr && !busy) begin
            stg[wptr]     <= stg_data;
            stg_vld[wptr] <= 1'b1;
            wptr          <= (wptr == PTR_W'(NUM_SECT-1)) ? '0 : wptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            tmr  <= '0;
            for (int i = 0; i < NUM_SECT; i++) cur[i] <= '0;
        end else if (prog_go && !busy) begin
            busy <= 1'b1;
            tmr  <= CNT_W'(PROG_CYCLES - 1);
        end else if (busy) begin
            if (tmr == '0) begin
                busy <= 1'b0;
                for (int i = 0; i < NUM_SECT; i++)
                    if (stg_vld[i]) cur[i] <= stg[i];
            end else begin
                tmr <= tmr - 1'b1;
            end
        end
    end

    assign rd_byte = cur[rd_idx];

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_prot
        assign sect_prot[g] = prot_en && is_locked(cur[g]);
    end
endmodule

// File: rtl/sprot_spi_engine.sv
module sprot_spi_engine
    import sprot_pkg::*;
#(
    parameter int unsigned NUM_SECT    = 64,
    parameter int unsigned PROG_CYCLES = 2000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                spi_sck,
    input  logic                spi_cs_n,
    input  logic                spi_si,
    input  logic                prot_en,
    output logic                spi_so,
    output logic                spi_so_oe,
    output logic                busy,
    output logic [NUM_SECT-1:0] sect_prot
);
    localparam int unsigned PTR_W = $clog2(NUM_SECT);

    spi_ev_t           ev;
    logic              stg_clr, stg_wr, prog_go;
    logic [BYTE_W-1:0] stg_data, rd_byte;
    logic [PTR_W-1:0]  rd_idx;
    logic              so_oe;

    sprot_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si), .ev(ev)
    );

    sprot_cmd_fsm #(.PTR_W(PTR_W)) fsm_i (
        .clk(clk), .rst(rst), .ev(ev), .busy(busy), .rd_byte(rd_byte),
        .stg_clr(stg_clr), .stg_wr(stg_wr), .stg_data(stg_data),
        .prog_go(prog_go), .rd_idx(rd_idx), .so_bit(spi_so), .so_oe(so_oe)
    );

    sprot_store #(.NUM_SECT(NUM_SECT), .PTR_W(PTR_W), .PROG_CYCLES(PROG_CYCLES)) store_i (
        .clk(clk), .rst(rst), .stg_clr(stg_clr), .stg_wr(stg_wr), .stg_data(stg_data),
        .prog_go(prog_go), .rd_idx(rd_idx), .prot_en(prot_en), .rd_byte(rd_byte),
        .busy(busy), .sect_prot(sect_prot)
    );

    assign spi_so_oe = so_oe;
endmodule

// File: rtl/sprot_spi_engine_chk.sv
module sprot_spi_engine_chk #(
    parameter int unsigned NUM_SECT    = 64,
    parameter int unsigned PROG_CYCLES = 2000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                spi_cs_n,
    input logic                spi_so_oe,
    input logic                prot_en,
    input logic                busy,
    input logic [NUM_SECT-1:0] sect_prot
);
    localparam int unsigned RUN_W = $clog2(PROG_CYCLES + 2) + 1;
    localparam int unsigned CS_W  = $clog2(SYNC_STAGES + 4) + 1;

    logic [RUN_W-1:0] busy_run;
    logic [CS_W-1:0]  cs_hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run  <= '0;
            cs_hi_run <= '0;
        end else begin
            busy_run <= busy ? busy_run + 1'b1 : '0;
            if (!spi_cs_n)                                  cs_hi_run <= '0;
            else if (cs_hi_run < CS_W'(SYNC_STAGES + 3))    cs_hi_run <= cs_hi_run + 1'b1;
        end
    end

    p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_run == RUN_W'(PROG_CYCLES));

    p_prot_hold_r4: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && $stable(prot_en) |-> $stable(sect_prot));

    p_no_read_busy_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !spi_so_oe);

    p_oe_off_r6: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n && cs_hi_run >= CS_W'(SYNC_STAGES + 2) |-> !spi_so_oe);

    p_prot_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !prot_en |-> sect_prot == '0);
endmodule

bind sprot_spi_engine sprot_spi_engine_chk #(
    .NUM_SECT(NUM_SECT), .PROG_CYCLES(PROG_CYCLES), .SYNC_STAGES(SYNC_STAGES)
) chk_i (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_so_oe(spi_so_oe),
    .prot_en(prot_en), .busy(busy), .sect_prot(sect_prot)
);

// File: tb/sprot_spi_engine_tb_top.sv
module sprot_spi_engine_tb_top;
    localparam int NS   = 64;
    localparam int PC   = 300;
    localparam int HALF = 6;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, prot_en = 1'b1;
    logic so, so_oe, busy;
    logic [NS-1:0] sect_prot;

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0] model [NS];
    exp_item_t exp_q[$];
    logic [7:0] act_q[$];

    always #5 clk = ~clk;

    sprot_spi_engine #(.NUM_SECT(NS), .PROG_CYCLES(PC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .prot_en(prot_en), .spi_so(so), .spi_so_oe(so_oe), .busy(busy),
        .sect_prot(sect_prot)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NS-1:0] exp_prot(input logic en);
        logic [NS-1:0] v;
        for (int i = 0; i < NS; i++) v[i] = en && (model[i] == 8'hFF);
        return v;
    endfunction

    task automatic sel_begin();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic sel_end();
        sck = 1'b0;
        tick(HALF);
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            si  = b[i];
            tick(HALF);
            r[i] = so;
            sck = 1'b1;
            tick(HALF);
        end
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r;
        xfer(b, r);
    endtask

    // Program command; the model is updated only if the command is expected to be accepted
    task automatic prog_cmd(input logic [7:0] p3, input logic [7:0] d[$], input bit accept);
        sel_begin();
        send(8'h3D); send(8'h2A); send(8'h7F); send(p3);
        foreach (d[k]) send(d[k]);
        sel_end();
        if (accept) foreach (d[k]) model[k % NS] = d[k];
    endtask

    // Driver side of the scoreboard: pushes the expected readout, then captures actual bytes
    task automatic read_cmd(input string tag);
        logic [7:0] r;
        sel_begin();
        send(8'h32); send(8'hA5); send(8'h5A); send(8'hC3);
        for (int k = 0; k < NS; k++) begin
            exp_q.push_back('{v: model[k], tag: tag});
            xfer(8'h00, r);
            act_q.push_back(r);
        end
        check(so_oe === 1'b1, "R6", so_oe, 1);
        sel_end();
        check(so_oe === 1'b0, "R6", so_oe, 0);
    endtask

    task automatic wait_idle();
        while (busy !== 1'b0) tick(1);
        tick(3);
    endtask

    // Monitor side of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                exp_item_t e;
                logic [7:0] a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                check(a === e.v, e.tag, a, e.v);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d[$];
        logic [7:0] r;
        logic [NS-1:0] old_prot;
        for (int i = 0; i < NS; i++) model[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(5);

        // R10: reset state
        check(busy === 1'b0, "R10", busy, 0);
        check(sect_prot === '0, "R10", sect_prot, 0);
        check(so_oe === 1'b0, "R10", so_oe, 0);
        read_cmd("R10");

        // R1, R2, R4, R7: full program, values cycle through 0xFF, 0x00, other
        d = {};
        for (int i = 0; i < NS; i++)
            d.push_back((i % 3 == 0) ? 8'hFF : (i % 3 == 1) ? 8'h00 : 8'(i * 4 + 1));
        old_prot = sect_prot;
        prog_cmd(8'hFC, d, 1);
        check(busy === 1'b1, "R4", busy, 1);
        check(sect_prot === old_prot, "R4", sect_prot, old_prot);
        tick(PC - 60);
        check(busy === 1'b1, "R4", busy, 1);
        check(sect_prot === old_prot, "R4", sect_prot, old_prot);
        tick(70);
        check(busy === 1'b0, "R4", busy, 0);
        check(sect_prot === exp_prot(1), "R7", sect_prot, exp_prot(1));

        // R5: serial readout of every sector
        read_cmd("R5");

        // R3: partial program touches sectors 0..2 only
        d = {8'hFF, 8'hFF, 8'hFF};
        prog_cmd(8'hFC, d, 1);
        wait_idle();
        check(sect_prot === exp_prot(1), "R3", sect_prot, exp_prot(1));
        read_cmd("R3");

        // R2: 66 bytes, the last two wrap to sectors 0 and 1
        d = {};
        for (int i = 0; i < NS; i++) d.push_back(i[0] ? 8'hFF : 8'h11);
        d.push_back(8'h44);
        d.push_back(8'hFF);
        prog_cmd(8'hFC, d, 1);
        wait_idle();
        check(sect_prot[1:0] === 2'b10, "R2", sect_prot[1:0], 2'b10);
        read_cmd("R2");

        // R1: broken fourth prefix byte, selection ignored
        d = {8'h00, 8'h00, 8'h00, 8'h00};
        prog_cmd(8'h30, d, 0);
        check(busy === 1'b0, "R1", busy, 0);
        tick(PC + 20);
        check(sect_prot === exp_prot(1), "R1", sect_prot, exp_prot(1));
        read_cmd("R1");

        // R9: program started while busy is ignored
        d = {};
        for (int i = 0; i < NS; i++) d.push_back(i < 32 ? 8'hFF : 8'h00);
        prog_cmd(8'hFC, d, 1);
        check(busy === 1'b1, "R9", busy, 1);
        d = {};
        for (int i = 0; i < NS; i++) d.push_back(8'h00);
        prog_cmd(8'hFC, d, 0);
        tick(10);
        check(busy === 1'b0, "R9", busy, 0);
        check(sect_prot === exp_prot(1), "R9", sect_prot, exp_prot(1));

        // R9: read started while busy never drives SO
        d = {8'h5A};
        prog_cmd(8'hFC, d, 1);
        sel_begin();
        send(8'h32); send(8'h00); send(8'h00); send(8'h00);
        xfer(8'h00, r);
        check(so_oe === 1'b0, "R9", so_oe, 0);
        sel_end();
        wait_idle();
        read_cmd("R9");

        // R7, R8: program with protection disabled, then enable
        prot_en = 1'b0;
        tick(2);
        check(sect_prot === '0, "R7", sect_prot, 0);
        d = {};
        for (int i = 0; i < NS; i++) d.push_back(i[1] ? 8'hFF : 8'h7E);
        prog_cmd(8'hFC, d, 1);
        check(busy === 1'b1, "R8", busy, 1);
        wait_idle();
        check(sect_prot === '0, "R7", sect_prot, 0);
        prot_en = 1'b1;
        tick(2);
        check(sect_prot === exp_prot(1), "R8", sect_prot, exp_prot(1));

        while (act_q.size() > 0) tick(1);
        tick(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule